// File: doc/BRIEF.md
# Grouped Peripheral Interrupt Expander

This block gathers a large set of peripheral interrupt pulses and funnels them onto a small number of CPU request lines. Sources are organised as groups of channels (12 groups of 16 by default, 192 sources). A rising edge on a source input latches a pending flag for that channel. Each channel also has its own enable bit. Each group has one request line toward the CPU. The line is raised when the block is globally switched on, the group is not waiting for an acknowledge, and at least one channel in the group is both pending and enabled.

When the CPU accepts a group by pulsing that group's take input, the block resolves the lowest-numbered pending and enabled channel. In the same cycle it returns a flat vector index, group times channels-per-group plus channel, so that every source can select its own handler. On the clock edge that ends that cycle it clears the chosen flag and marks the group as blocked. Software then writes a 1 to the group's acknowledge bit to unblock it. Flags, enables, the global switch and the blocking bits are reached through a simple synchronous register port with registered read data.

Register map (6-bit word address): 0x00 control, where bit 0 is the global enable. 0x01 acknowledge: a read returns the blocking bits, and a write of 1 to bit g unblocks group g. 0x10+g holds the enable mask of group g. 0x20+g holds the pending flags of group g; a write of 1 to a bit clears that flag.

Top module: `irq_group_expander`

## Requirements
- R1: After reset, all flags, enables and blocking bits and the global enable are 0. Every group request line is low and vec_valid is low.
- R2: A 0-to-1 transition on irq_in[g*16+c] sets flag bit c of group g, and the flag reads back at address 0x20+g after the edge that samples it. A level held high sets the flag only once; after a clear it is not set again.
- R3: grp_req[g] is high exactly when control bit 0 is 1, blocking bit g is 0, and some channel of group g has both its flag and its enable set. Without a take or a register write, a high request stays high.
- R4: A flag set while its enable bit is 0 stays latched. Writing the enable bit to 1 at 0x10+g raises grp_req[g] in the cycle after the write.
- R5: When grp_take[g] is high while grp_req[g] is high, vec_valid is high in that same cycle and vec_idx equals g*16 plus the lowest channel number that is pending and enabled.
- R6: After a take, the chosen channel's flag is cleared, blocking bit g (bit g of address 0x01) is set, and grp_req[g] is low from the next cycle on.
- R7: Writing 1 to bit g of address 0x01 clears blocking bit g, and grp_req[g] reasserts in the next cycle if enabled flags remain. Writing 0 to a bit leaves that bit unchanged.
- R8: A take on a group whose request is low is ignored: vec_valid stays low and no flag or blocking bit changes. When several requesting groups are taken at once, only the lowest-numbered group is served.
- R9: Writing 1s to address 0x20+g clears those flags. A rising edge on a channel in the same cycle as its clear leaves the flag set.
- R10: Read data appears on reg_rdata in the cycle after the read strobe. Addresses outside the map read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 192 | Peripheral interrupt sources, channel c of group g at bit g*16+c |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| grp_take | input | 12 | CPU accepts group g (bit g) |
| grp_req | output | 12 | Per-group request toward the CPU |
| vec_valid | output | 1 | A take was accepted this cycle |
| vec_idx | output | 8 | Flat vector index of the accepted channel |

## Verification
The bench targets priority resolution when several channels of one group are pending, including a channel that is pending but disabled and sits below the winner. A design that ignores the enable mask or picks the highest bit would return the wrong vector there. It checks that a group stays silent after a take until acknowledged, that a write of 0 to the acknowledge register does not unblock anything, and that the line comes back at once when flags remain. A design that auto-unblocks or loses the remaining flags would fail these checks. It also covers a flag raised while disabled, a clear racing a new edge, a held-high input that must not re-arm the flag, simultaneous takes of two groups, and a take of an idle group. These expose designs that drop latched events, retrigger on level, or serve the wrong group.

// File: rtl/irqx_pkg.sv
package irqx_pkg;

    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] A_CTRL      = 6'h00;
    localparam logic [ADDR_W-1:0] A_ACK       = 6'h01;
    localparam logic [ADDR_W-1:0] A_EN_BASE   = 6'h10;
    localparam logic [ADDR_W-1:0] A_FLAG_BASE = 6'h20;

    // Address falls in a bank of n consecutive words starting at base.
    function automatic logic in_bank(input logic [ADDR_W-1:0] addr,
                                     input logic [ADDR_W-1:0] base,
                                     input int n);
        return (int'(addr) >= int'(base)) && (int'(addr) < int'(base) + n);
    endfunction

endpackage

// File: rtl/irqx_edge_det.sv
module irqx_edge_det #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);

    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
        rise   = lvl & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

endmodule

// File: rtl/irqx_lowest_pick.sv
module irqx_lowest_pick #(
    parameter int W  = 16,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [W-1:0]  onehot
);

    always_comb begin
        found = |req;
        idx   = '0;
        // Walk downward so the lowest set bit is written last and wins.
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        onehot = found ? (W'(1) << idx) : '0;
    end

endmodule

// File: rtl/irqx_group_slice.sv
module irqx_group_slice #(
    parameter int NC = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NC-1:0] rise,
    input  logic          en_wr,
    input  logic          flag_wr,
    input  logic [NC-1:0] wdata,
    input  logic [NC-1:0] take_mask,
    output logic [NC-1:0] flag_o,
    output logic [NC-1:0] en_o
);

    typedef struct packed {
        logic [NC-1:0] flag;
        logic [NC-1:0] en;
    } slice_t;

    slice_t        s_d, s_q;
    logic [NC-1:0] clr_d;

    always_comb begin
        s_d   = s_q;
        clr_d = take_mask | (flag_wr ? wdata : '0);
        // A new edge outranks any clear in the same cycle.
        s_d.flag = (s_q.flag & ~clr_d) | rise;
        if (en_wr) s_d.en = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flag_o = s_q.flag;
    assign en_o   = s_q.en;

endmodule

// File: rtl/irq_group_expander.sv
module irq_group_expander
    import irqx_pkg::*;
#(
    parameter int NUM_GRP = 12,
    parameter int GRP_CH  = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NUM_GRP*GRP_CH-1:0]              irq_in,
    input  logic                                   reg_en,
    input  logic                                   reg_we,
    input  logic [ADDR_W-1:0]                      reg_addr,
    input  logic [GRP_CH-1:0]                      reg_wdata,
    output logic [GRP_CH-1:0]                      reg_rdata,
    input  logic [NUM_GRP-1:0]                     grp_take,
    output logic [NUM_GRP-1:0]                     grp_req,
    output logic                                   vec_valid,
    output logic [$clog2(NUM_GRP*GRP_CH)-1:0]      vec_idx
);

    localparam int TOTAL = NUM_GRP * GRP_CH;
    localparam int CH_W  = $clog2(GRP_CH);
    localparam int GRP_W = $clog2(NUM_GRP);
    localparam int VEC_W = $clog2(TOTAL);

    typedef struct packed {
        logic               gen_en;
        logic [NUM_GRP-1:0] blk;
        logic [GRP_CH-1:0]  rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [TOTAL-1:0]                rise;
    logic [NUM_GRP-1:0][GRP_CH-1:0]  flag_q, en_q, pend, pick_hot, take_mask;
    logic [NUM_GRP-1:0][CH_W-1:0]    pick_idx;
    logic [NUM_GRP-1:0]              pick_any, en_wr, flag_wr;
    logic [NUM_GRP-1:0]              take_ok, tk_hot;
    logic [GRP_W-1:0]                tk_grp;
    logic                            tk_found;
    logic [CH_W-1:0]                 sel_ch;
    logic [GRP_CH-1:0]               rd_mux;
    logic                            wr_go, rd_go;

    assign wr_go = reg_en & reg_we;
    assign rd_go = reg_en & ~reg_we;

    irqx_edge_det #(.W(TOTAL)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (irq_in),
        .rise (rise)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        assign en_wr[g]   = wr_go && (reg_addr == A_EN_BASE   + ADDR_W'(g));
        assign flag_wr[g] = wr_go && (reg_addr == A_FLAG_BASE + ADDR_W'(g));
        assign take_mask[g] = tk_hot[g] ? pick_hot[g] : '0;
        assign pend[g] = flag_q[g] & en_q[g];

        irqx_group_slice #(.NC(GRP_CH)) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .rise     (rise[g*GRP_CH +: GRP_CH]),
            .en_wr    (en_wr[g]),
            .flag_wr  (flag_wr[g]),
            .wdata    (reg_wdata),
            .take_mask(take_mask[g]),
            .flag_o   (flag_q[g]),
            .en_o     (en_q[g])
        );

        irqx_lowest_pick #(.W(GRP_CH), .IW(CH_W)) u_ch_pick (
            .req   (pend[g]),
            .found (pick_any[g]),
            .idx   (pick_idx[g]),
            .onehot(pick_hot[g])
        );
    end

    assign grp_req = {NUM_GRP{ctl_q.gen_en}} & ~ctl_q.blk & pick_any;
    assign take_ok = grp_take & grp_req;

    irqx_lowest_pick #(.W(NUM_GRP), .IW(GRP_W)) u_grp_pick (
        .req   (take_ok),
        .found (tk_found),
        .idx   (tk_grp),
        .onehot(tk_hot)
    );

    always_comb begin
        sel_ch = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (tk_hot[g]) sel_ch = pick_idx[g];
        end
    end

    assign vec_valid = tk_found;
    assign vec_idx   = tk_found ? VEC_W'(int'(tk_grp) * GRP_CH + int'(sel_ch)) : '0;

    always_comb begin
        rd_mux = '0;
        if (reg_addr == A_CTRL) rd_mux[0] = ctl_q.gen_en;
        if (reg_addr == A_ACK)  rd_mux[NUM_GRP-1:0] = ctl_q.blk;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (reg_addr == A_EN_BASE   + ADDR_W'(g)) rd_mux = en_q[g];
            if (reg_addr == A_FLAG_BASE + ADDR_W'(g)) rd_mux = flag_q[g];
        end
    end

    always_comb begin
        ctl_d = ctl_q;
        if (wr_go && reg_addr == A_CTRL) ctl_d.gen_en = reg_wdata[0];
        if (wr_go && reg_addr == A_ACK)  ctl_d.blk = ctl_q.blk & ~reg_wdata[NUM_GRP-1:0];
        // A take in the same cycle as an acknowledge keeps the group blocked.
        ctl_d.blk = ctl_d.blk | tk_hot;
        if (rd_go) ctl_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign reg_rdata = ctl_q.rdata;

endmodule

// File: rtl/irqx_checker.sv
module irqx_checker
    import irqx_pkg::*;
#(
    parameter int NUM_GRP = 12,
    parameter int GRP_CH  = 16
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [NUM_GRP-1:0]                grp_take,
    input logic [NUM_GRP-1:0]                grp_req,
    input logic                              vec_valid,
    input logic [$clog2(NUM_GRP*GRP_CH)-1:0] vec_idx,
    input logic                              reg_en,
    input logic                              reg_we,
    input logic [ADDR_W-1:0]                 reg_addr,
    input logic [GRP_CH-1:0]                 reg_rdata
);

    localparam int TOTAL = NUM_GRP * GRP_CH;

    logic [NUM_GRP-1:0] tk_mask, served;
    logic               unmapped;

    always_comb begin
        tk_mask = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (vec_valid && (int'(vec_idx) / GRP_CH == g)) tk_mask[g] = 1'b1;
        end
        served   = grp_take & grp_req;
        unmapped = (reg_addr != A_CTRL) && (reg_addr != A_ACK)
                && !in_bank(reg_addr, A_EN_BASE, NUM_GRP)
                && !in_bank(reg_addr, A_FLAG_BASE, NUM_GRP);
    end

    p_valid_from_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (served != '0));

    p_vec_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (int'(vec_idx) < TOTAL));

    p_take_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> ((grp_req & $past(tk_mask)) == '0));

    p_lowest_group_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (((tk_mask & served) != '0) && ((served & (tk_mask - 1'b1)) == '0)));

    p_idle_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (served == '0) |-> !vec_valid);

    p_req_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_en && reg_we) |=> (($past(grp_req) & ~$past(grp_take) & ~grp_req) == '0));

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && !reg_we && unmapped) |=> (reg_rdata == '0));

endmodule

bind irq_group_expander irqx_checker #(.NUM_GRP(NUM_GRP), .GRP_CH(GRP_CH)) u_chk (.*);

// File: tb/sim_irq_group_expander.sv
`timescale 1ns/1ps
module sim_irq_group_expander;

    localparam int NG = 12;
    localparam int NC = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NG*NC-1:0] irq_in = '0;
    logic            reg_en = 1'b0;
    logic            reg_we = 1'b0;
    logic [5:0]      reg_addr = '0;
    logic [15:0]     reg_wdata = '0;
    logic [15:0]     reg_rdata;
    logic [NG-1:0]   grp_take = '0;
    logic [NG-1:0]   grp_req;
    logic            vec_valid;
    logic [7:0]      vec_idx;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    irq_group_expander u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .grp_take(grp_take), .grp_req(grp_req),
        .vec_valid(vec_valid), .vec_idx(vec_idx)
    );

    typedef struct packed {
        logic [3:0]  grp;
        logic [15:0] en;
        logic [15:0] pulse;
        logic [3:0]  ch;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VTAB [NV] = '{
        '{4'd0,  16'hFFFF, 16'h0001, 4'd0},
        '{4'd3,  16'hFFFF, 16'h8010, 4'd4},
        '{4'd11, 16'hF0F0, 16'h0F11, 4'd4},
        '{4'd5,  16'h00FF, 16'hFF00, 4'd0},
        '{4'd7,  16'hFFFF, 16'hC000, 4'd14},
        '{4'd11, 16'h8001, 16'h8001, 4'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_en = 1'b0;
        d = reg_rdata;
    endtask

    task automatic pulse(input int g, input logic [15:0] m);
        @(negedge clk);
        irq_in[g*NC +: NC] = m;
        @(negedge clk);
        irq_in[g*NC +: NC] = '0;
    endtask

    task automatic take(input logic [NG-1:0] t, output logic v, output logic [7:0] idx);
        @(negedge clk);
        grp_take = t;
        #1;
        v = vec_valid;
        idx = vec_idx;
        @(negedge clk);
        grp_take = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic        v;
        logic [7:0]  idx;

        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 req", 32'(grp_req), 0);
        check("R1 valid", 32'(vec_valid), 0);
        rst_n = 1'b1;
        rd(6'h00, d); check("R1 ctrl", 32'(d), 0);
        rd(6'h01, d); check("R1 ack", 32'(d), 0);
        rd(6'h13, d); check("R1 en", 32'(d), 0);
        rd(6'h2B, d); check("R1 flag", 32'(d), 0);

        // R3: global enable off keeps lines quiet
        wr(6'h12, 16'h0004);
        pulse(2, 16'h0004);
        check("R3 off", 32'(grp_req), 0);
        wr(6'h00, 16'h0001);
        check("R3 on", 32'(grp_req), 32'h004);
        take(12'h004, v, idx);
        check("R5 idx g2", 32'(idx), 34);
        wr(6'h01, 16'h0004);
        wr(6'h12, 16'h0000);

        // Table walk: R3, R5, R6, R7, R9
        for (int i = 0; i < NV; i++) begin
            int g;
            logic has;
            logic [15:0] rest;
            g = int'(VTAB[i].grp);
            has = |(VTAB[i].en & VTAB[i].pulse);
            rest = VTAB[i].pulse & ~(16'h1 << VTAB[i].ch);
            wr(6'h10 + 6'(g), VTAB[i].en);
            pulse(g, VTAB[i].pulse);
            check("R3 req", 32'(grp_req[g]), 32'(has));
            if (has) begin
                take(NG'(1) << g, v, idx);
                check("R5 valid", 32'(v), 1);
                check("R5 idx", 32'(idx), 32'(g * NC + int'(VTAB[i].ch)));
                check("R6 req low", 32'(grp_req[g]), 0);
                rd(6'h20 + 6'(g), d); check("R6 flag", 32'(d), 32'(rest));
                rd(6'h01, d); check("R6 blk", 32'(d), 32'(16'h1 << g));
                wr(6'h01, 16'h1 << g);
                check("R7 rearm", 32'(grp_req[g]), 32'(|(rest & VTAB[i].en)));
            end
            wr(6'h20 + 6'(g), 16'hFFFF);
            rd(6'h20 + 6'(g), d); check("R9 clear", 32'(d), 0);
            wr(6'h10 + 6'(g), 16'h0000);
        end

        // R4: latched while disabled
        pulse(2, 16'h0200);
        check("R4 held", 32'(grp_req), 0);
        wr(6'h12, 16'h0200);
        check("R4 fwd", 32'(grp_req), 32'h004);
        take(12'h004, v, idx);
        check("R4 idx", 32'(idx), 41);
        wr(6'h01, 16'h0004);

        // R8: idle take, then two groups taken together
        take(12'h040, v, idx);
        check("R8 idle", 32'(v), 0);
        rd(6'h01, d); check("R8 idle blk", 32'(d), 0);
        wr(6'h11, 16'hFFFF);
        wr(6'h14, 16'hFFFF);
        pulse(1, 16'h0004);
        pulse(4, 16'h0001);
        take(12'h012, v, idx);
        check("R8 lowest grp", 32'(idx), 18);
        check("R8 other kept", 32'(grp_req), 32'h010);
        take(12'h010, v, idx);
        check("R8 g4 idx", 32'(idx), 64);

        // R7: writing 0 leaves block, 1 releases it
        wr(6'h01, 16'h0000);
        rd(6'h01, d); check("R7 zero write", 32'(d), 32'h0012);
        pulse(4, 16'h0002);
        check("R7 still blk", 32'(grp_req[4]), 0);
        wr(6'h01, 16'h0010);
        check("R7 release", 32'(grp_req[4]), 1);
        take(12'h010, v, idx);
        check("R7 idx", 32'(idx), 65);
        wr(6'h01, 16'h0012);

        // R9: edge wins over a clear in the same cycle
        @(negedge clk);
        irq_in[9*NC + 3] = 1'b1;
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = 6'h29; reg_wdata = 16'hFFFF;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0; irq_in[9*NC + 3] = 1'b0;
        rd(6'h29, d); check("R9 set wins", 32'(d), 32'h0008);
        wr(6'h29, 16'hFFFF);

        // R2: held level sets once
        @(negedge clk); irq_in[9*NC + 5] = 1'b1;
        @(negedge clk);
        rd(6'h29, d); check("R2 set", 32'(d), 32'h0020);
        wr(6'h29, 16'h0020);
        repeat (3) @(negedge clk);
        rd(6'h29, d); check("R2 no reset", 32'(d), 0);
        irq_in[9*NC + 5] = 1'b0;

        // R10: unmapped address and read latency
        rd(6'h3F, d); check("R10 unmapped", 32'(d), 0);
        rd(6'h11, d); check("R10 read en", 32'(d), 32'hFFFF);

        // R3: switching global enable off drops a pending line
        wr(6'h11, 16'hFFFF);
        pulse(1, 16'h0100);
        check("R3 pending", 32'(grp_req), 32'h002);
        wr(6'h00, 16'h0000);
        check("R3 gated", 32'(grp_req), 0);
        wr(6'h00, 16'h0001);
        check("R3 back", 32'(grp_req), 32'h002);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule